// File: doc/BRIEF.md
# Channel Status Change Flag

This block sits behind the frame decoder of a digital audio receiver. The decoder delivers one channel status bit with every frame, and the status word spans a block of 192 frames. The block records the leading 48 status bits of each block and compares them with the same 48 bits of the block before. It drives one flag. The flag is high when the leading bits differ from the last block, and low when they repeat. Status logic downstream waits for a falling edge of the flag. After that edge, the status it has read is current.

A receiver fault forces the flag high and throws away the comparison history. The flag can drop again only after two clean, complete blocks. The first of them reloads the history, and the second confirms that the leading bits did not change. Blocks that end early or run past 192 frames are treated the same way as a fault.

Top module: `cs_change_flag`

## Requirements
- R1: While `rst_n` is low at a clock edge, `cs_changed` becomes 1 and the stored history becomes invalid. The first complete block after reset only loads the history, and the flag stays 1 through it.
- R2: Only status positions 0 to 47 of a block enter the comparison. Bits at positions 48 to 191 never change `cs_changed`.
- R3: When the history is valid, `cs_changed` becomes 0 if positions 0..47 of the current block equal those of the previous block. It becomes 1 if any of them differ.
- R4: The new value shows on `cs_changed` in the clock cycle after the `frame_stb` cycle that carries position 47. Outside such updates and the fault cases, the flag keeps its value, so a result is held for the whole block.
- R5: In every cycle in which `rx_err` is 1, the flag becomes 1 at the next edge, the history becomes invalid and block tracking stops. Frames presented while `rx_err` is 1 are ignored.
- R6: After `rx_err` returns to 0, nothing is tracked until a frame with `blk_start`=1. The first complete block from there only reloads the history, and the second block is compared.
- R7: A `frame_stb` with `blk_start`=1 arriving before frame 191 of a tracked block discards that block. The flag becomes 1 and the history becomes invalid. The new block starts at position 0.
- R8: A frame without `blk_start` after frame 191 of a tracked block means lost alignment. The flag becomes 1, the history becomes invalid, and tracking waits for the next `blk_start`.
- R9: `cs_bit` and `blk_start` are sampled only in cycles with `frame_stb`=1, and `blk_start`=1 marks position 0. Frames seen before any `blk_start` do not affect the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_stb | input | 1 | One-cycle strobe per received frame |
| cs_bit | input | 1 | Channel status bit of this frame, valid with `frame_stb` |
| blk_start | input | 1 | Marks the frame at position 0 of a status block, valid with `frame_stb` |
| rx_err | input | 1 | Receiver fault or lost lock, level sensitive |
| cs_changed | output | 1 | 1 = leading status bits changed or not yet confirmed; 0 = confirmed unchanged |

## Verification
The decision at position 47 and a fault can land in the same cycle. The bench provokes this by raising `rx_err` in exactly the frame that carries bit 47 of a block whose leading bits repeat the previous block. The fault must win: the flag stays 1 and the history is lost. A behavioural model in the bench uses bit queues and a frame counter and is compared with `cs_changed` on every clock. That comparison shows that the following two blocks are needed before the flag can fall again. An early block start is also placed one frame short of a full block, so that the discard path and the normal restart use the same `blk_start` frame.

// File: rtl/cs_chg_pkg.sv
// Package cs_chg_pkg
// Holds the default geometry of a status block and the verdict record that
// the compare store hands to the flag control. Assumes nothing else.
package cs_chg_pkg;
    localparam int DEF_CMP_BITS   = 48;
    localparam int DEF_BLK_FRAMES = 192;

    // Result of one block comparison, produced in the position-47 frame.
    typedef struct packed {
        logic dec;      // a decision is taken in this cycle
        logic same;     // leading bits equal the stored history
        logic hist_ok;  // the stored history was valid for this decision
    } cs_verdict_t;
endpackage

// File: rtl/cs_frame_track.sv
// Module cs_frame_track
// Tracks the frame position within a status block. A block begins at a
// frame with blk_start. Ends early, overruns or a receiver fault raise
// 'abort'. Assumes frame_stb is a single-cycle strobe and that blk_start is
// meaningful only alongside it.
module cs_frame_track #(
    parameter int BLK_FRAMES = 192,
    parameter int POS_W      = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_stb,
    input  logic             blk_start,
    input  logic             rx_err,
    output logic             pos_stb,
    output logic [POS_W-1:0] pos,
    output logic             abort
);
    localparam logic [POS_W-1:0] LAST = POS_W'(BLK_FRAMES - 1);

    logic [POS_W-1:0] idx_q;
    logic             in_blk_q;
    logic             fr_ok, at_end, early, lost;

    // Classify the current frame against the tracked block position.
    always_comb begin
        fr_ok   = frame_stb & ~rx_err;
        at_end  = in_blk_q & (idx_q == LAST);
        early   = fr_ok & blk_start & in_blk_q & ~at_end;
        lost    = fr_ok & ~blk_start & at_end;
        pos     = blk_start ? '0 : idx_q + 1'b1;
        pos_stb = fr_ok & (blk_start | (in_blk_q & ~at_end));
        abort   = rx_err | early | lost;
    end

    // Advance the position counter and the in-block state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q    <= '0;
            in_blk_q <= 1'b0;
        end else if (rx_err) begin
            in_blk_q <= 1'b0;
        end else if (frame_stb) begin
            if (blk_start) begin
                idx_q    <= '0;
                in_blk_q <= 1'b1;
            end else if (at_end) begin
                in_blk_q <= 1'b0;
            end else if (in_blk_q) begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    // R7: a reported position never leaves the block.
    a_r7_pos_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        pos_stb |-> (pos <= LAST));
    // R9: with no block tracked, only a block start yields a position.
    a_r9_idle_until_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_blk_q && !blk_start) |-> !pos_stb);
endmodule

// File: rtl/cs_cmp_store.sv
// Module cs_cmp_store
// Collects the leading CMP_BITS status bits of a block and compares each one
// with the history of the previous block as it arrives. At the last compared
// position it issues a verdict and moves the captured bits into the history.
// Assumes positions come in order, starting at 0 for each block.
module cs_cmp_store
    import cs_chg_pkg::*;
#(
    parameter int CMP_BITS = 48,
    parameter int POS_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pos_stb,
    input  logic [POS_W-1:0] pos,
    input  logic             cs_bit,
    input  logic             abort,
    output cs_verdict_t      verdict
);
    localparam int               CW      = (CMP_BITS > 1) ? $clog2(CMP_BITS) : 1;
    localparam logic [POS_W-1:0] CMP_END = POS_W'(CMP_BITS);
    localparam logic [POS_W-1:0] CMP_LST = POS_W'(CMP_BITS - 1);

    logic [CMP_BITS-1:0] cap_q, cap_next, hist_q;
    logic                diff_q, diff_next, hval_q, wr;
    logic [CW-1:0]       bidx;

    // Insert the incoming bit and fold its mismatch into the block result.
    always_comb begin
        wr       = pos_stb & (pos < CMP_END);
        bidx     = pos[CW-1:0];
        cap_next = cap_q;
        if (wr) cap_next[bidx] = cs_bit;
        diff_next = ((pos == '0) ? 1'b0 : diff_q) | (wr & (hist_q[bidx] ^ cs_bit));
        verdict.dec     = pos_stb & (pos == CMP_LST);
        verdict.same    = ~diff_next;
        verdict.hist_ok = hval_q;
    end

    // Hold the captured bits, the running mismatch and the history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q  <= '0;
            hist_q <= '0;
            diff_q <= 1'b0;
            hval_q <= 1'b0;
        end else begin
            if (wr) begin
                cap_q  <= cap_next;
                diff_q <= diff_next;
            end
            if (abort) begin
                hval_q <= 1'b0;
            end else if (verdict.dec) begin
                hist_q <= cap_next;
                hval_q <= 1'b1;
            end
        end
    end

    // R5 R7 R8: any abort leaves the history invalid.
    a_r5_abort_invalidates: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !verdict.hist_ok);
    // R6: a decision without an abort leaves a valid history behind.
    a_r6_fill_validates: assert property (@(posedge clk) disable iff (!rst_n)
        (verdict.dec && !abort) |=> verdict.hist_ok);
endmodule

// File: rtl/cs_flag_ctl.sv
// Module cs_flag_ctl
// Owns the output flag. Any abort forces the flag high. A verdict clears it
// only if the history was valid and the bits matched. Assumes at most one
// verdict per block.
module cs_flag_ctl
    import cs_chg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        abort,
    input  logic        rx_err,
    input  cs_verdict_t verdict,
    output logic        flag
);
    logic flag_q;

    // Update the flag on faults and on block verdicts only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b1;
        end else if (abort) begin
            flag_q <= 1'b1;
        end else if (verdict.dec) begin
            flag_q <= ~(verdict.hist_ok & verdict.same);
        end
    end

    assign flag = flag_q;

    // R5: a receiver fault drives the flag high at the next edge.
    a_r5_err_forces_high: assert property (@(posedge clk) disable iff (!rst_n)
        rx_err |=> flag);
    // R4: with no verdict and no abort the flag holds.
    a_r4_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        (!verdict.dec && !abort) |=> $stable(flag));
endmodule

// File: rtl/cs_change_flag.sv
// Module cs_change_flag (top)
// Raises cs_changed whenever the leading channel status bits of a block
// differ from the previous block, or when the result is unproven after a
// reset, a fault or a broken block. Assumes one frame_stb per frame.
module cs_change_flag
    import cs_chg_pkg::*;
#(
    parameter int CMP_BITS   = DEF_CMP_BITS,
    parameter int BLK_FRAMES = DEF_BLK_FRAMES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_stb,
    input  logic cs_bit,
    input  logic blk_start,
    input  logic rx_err,
    output logic cs_changed
);
    localparam int POS_W = $clog2(BLK_FRAMES);

    logic             pos_stb, abort;
    logic [POS_W-1:0] pos;
    cs_verdict_t      verdict;

    cs_frame_track #(.BLK_FRAMES(BLK_FRAMES), .POS_W(POS_W)) u_track (
        .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .blk_start(blk_start),
        .rx_err(rx_err), .pos_stb(pos_stb), .pos(pos), .abort(abort)
    );

    cs_cmp_store #(.CMP_BITS(CMP_BITS), .POS_W(POS_W)) u_store (
        .clk(clk), .rst_n(rst_n), .pos_stb(pos_stb), .pos(pos),
        .cs_bit(cs_bit), .abort(abort), .verdict(verdict)
    );

    cs_flag_ctl u_flag (
        .clk(clk), .rst_n(rst_n), .abort(abort), .rx_err(rx_err),
        .verdict(verdict), .flag(cs_changed)
    );

    // R3: the flag can only fall on the strength of a valid history.
    a_r3_fall_needs_history: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_changed) |-> $past(verdict.hist_ok));
endmodule

// File: tb/cs_change_flag_test.sv
module cs_change_flag_test;
    localparam int CLK_P = 10;
    localparam int NCMP  = 48;
    localparam int NBLK  = 192;

    logic clk = 1'b0, rst_n = 1'b0;
    logic frame_stb = 1'b0, cs_bit = 1'b0, blk_start = 1'b0, rx_err = 1'b0;
    logic cs_changed;

    int    n_chk = 0, n_fail = 0;
    string scen = "R1";
    bit    started = 0;

    // reference model state
    bit m_flag = 1, m_ok = 0, m_on = 0;
    int m_cnt = 0;
    bit m_cur[$];
    bit m_hist[$];

    cs_change_flag uut (.*);

    always #(CLK_P/2) clk = ~clk;

    // Behavioural reference: one step per clock edge.
    always @(posedge clk) begin
        bit pushed;
        pushed = 0;
        started = 1;
        if (!rst_n) begin
            m_flag = 1; m_ok = 0; m_on = 0;
        end else if (rx_err) begin
            m_flag = 1; m_ok = 0; m_on = 0;
        end else if (frame_stb) begin
            if (blk_start) begin
                if (m_on && m_cnt != NBLK) begin m_flag = 1; m_ok = 0; end
                m_on = 1; m_cnt = 1;
                m_cur.delete(); m_cur.push_back(cs_bit); pushed = 1;
            end else if (m_on) begin
                if (m_cnt == NBLK) begin
                    m_on = 0; m_flag = 1; m_ok = 0;
                end else begin
                    if (m_cnt < NCMP) begin m_cur.push_back(cs_bit); pushed = 1; end
                    m_cnt++;
                end
            end
            if (pushed && m_cur.size() == NCMP) begin
                bit eq;
                eq = m_ok;
                if (m_ok)
                    for (int i = 0; i < NCMP; i++) if (m_cur[i] != m_hist[i]) eq = 0;
                m_flag = !eq;
                m_hist = m_cur;
                m_ok = 1;
            end
        end
    end

    // Compare every clock, away from the active edge.
    always @(negedge clk) begin
        if (started) begin
            n_chk++;
            if (cs_changed !== m_flag) begin
                n_fail++;
                $display("FAIL %s: cs_changed=%0b expected %0b at %0t", scen, cs_changed, m_flag, $time);
            end
        end
    end

    task automatic frame(input logic b, input logic st, input logic e);
        @(negedge clk);
        frame_stb = 1; cs_bit = b; blk_start = st; rx_err = e;
        @(negedge clk);
        frame_stb = 0; blk_start = 0; rx_err = 0; cs_bit = 1'($urandom);
        repeat ($urandom_range(0, 2)) @(negedge clk);
    endtask

    // Send len frames; positions below NCMP take head bits, the rest random.
    // err_pos >= 0 raises rx_err together with that frame.
    task automatic block(input logic [NCMP-1:0] head, input int len, input int err_pos);
        for (int i = 0; i < len; i++)
            frame((i < NCMP) ? head[i] : 1'($urandom), i == 0, i == err_pos);
    endtask

    initial begin
        #(CLK_P * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not finish, got hang expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [NCMP-1:0] pa, pb;
        pa = 48'h5A3C_0F81_E7D2;
        pb = pa ^ 48'h0000_0000_0001;
        repeat (3) @(negedge clk);
        n_chk++;
        if (cs_changed !== 1'b1) begin
            n_fail++;
            $display("FAIL R1: reset flag=%0b expected 1", cs_changed);
        end
        rst_n = 1;
        scen = "R9";
        for (int i = 0; i < 20; i++) frame(1'($urandom), 0, 0);
        scen = "R1";  block(pa, NBLK, -1);
        scen = "R3 R4 same"; block(pa, NBLK, -1);
        scen = "R2";  block(pa, NBLK, -1);
        scen = "R3 differ bit0"; block(pb, NBLK, -1);
        scen = "R3 same again"; block(pb, NBLK, -1);
        pb = pb ^ 48'h8000_0000_0000;
        scen = "R3 differ bit47"; block(pb, NBLK, -1);
        scen = "R5 mid-block"; block(pb, 100, 30);
        scen = "R6 fill"; block(pb, NBLK, -1);
        scen = "R6 compare"; block(pb, NBLK, -1);
        scen = "R5 same-cycle bit47"; block(pb, NBLK, 47);
        scen = "R6 fill2"; block(pb, NBLK, -1);
        scen = "R6 compare2"; block(pb, NBLK, -1);
        scen = "R7 short"; block(pb, NBLK - 1, -1);
        scen = "R7 restart"; block(pb, NBLK, -1);
        scen = "R7 compare"; block(pb, NBLK, -1);
        scen = "R8 overrun";
        for (int i = 0; i < 5; i++) frame(1'($urandom), 0, 0);
        scen = "R8 refill"; block(pa, NBLK, -1);
        scen = "R8 compare"; block(pa, NBLK, -1);
        scen = "R5 long error";
        repeat (4) begin @(negedge clk); rx_err = 1; end
        @(negedge clk); rx_err = 0;
        scen = "R6 after long error"; block(pa, NBLK, -1);
        block(pa, NBLK, -1);
        repeat (4) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule